// File: doc/BRIEF.md
# Multiplexed-Address Dynamic Memory Array Model

This block is a synthesizable behavioural model of a small dynamic memory. The storage holds a square grid of supercells, each WORD_W bits wide, with 2^ROW_BITS rows and 2^COL_BITS columns. The default is 4 x 4 supercells of 8 bits, 128 bits in total. A single narrow address bus carries the row index in one command and the column index in a later command. A row strobe copies the whole addressed row into an internal row buffer. Column strobes then read or update single supercells of that buffer. When the row is closed, or replaced by another row strobe, the buffer is written back into the array.

Stored contents are assumed to leak. A cycle counter raises a refresh-needed flag once a programmable number of cycles has elapsed. A refresh command is accepted only while no row is open. It walks every row through the row buffer, spending one cycle on the load and one cycle on the store for each row, and then drops the flag and restarts the count. A column strobe issued while no row is open does nothing except pulse an error output.

Top module: `mux_dram_core`

## Requirements
- R1: After reset, dout_o, col_err_o, ref_req_o and ref_busy_o are 0 and no row is open.
- R2: A cycle with row_stb_i high opens the row given by addr_i[ROW_BITS-1:0] and loads it into the row buffer. If another row is already open, that row is first written back to the array and dout_o is cleared to 0.
- R3: A column strobe with wr_en_i low, issued while a row is open, presents supercell (open row, addr_i[COL_BITS-1:0]) on dout_o one clock after the strobe cycle.
- R4: A column strobe with wr_en_i high, issued while a row is open, replaces that supercell in the row buffer with din_i. The written value appears on dout_o one clock later.
- R5: Writes reach the array when the row is written back. Each write changes only the addressed supercell and leaves every other supercell untouched.
- R6: dout_o holds its value until the next accepted column strobe. It clears to 0 when the open row is closed by row_close_i.
- R7: A column strobe issued while no row is open changes nothing and raises col_err_o for exactly one clock.
- R8: ref_req_o rises REFRESH_CYCLES clocks after the end of the last refresh. It then stays high until a refresh completes.
- R9: ref_start_i, issued with no row open and no refresh running, holds ref_busy_o high for 2 x 2^ROW_BITS clocks. During that time strobes are ignored. At the end ref_req_o is 0 and every stored supercell is unchanged.
- R10: ref_start_i issued while a row is open is ignored, and ref_busy_o stays low.
- R11: When several commands arrive in the same cycle, a row strobe wins over a close, and a close wins over a column strobe. Reopening the already-open row keeps the buffered writes of that row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| addr_i | input | max(ROW_BITS,COL_BITS) | Shared row/column index |
| row_stb_i | input | 1 | Open (or switch to) the row on addr_i |
| col_stb_i | input | 1 | Access the column on addr_i in the open row |
| row_close_i | input | 1 | Write back and close the open row |
| wr_en_i | input | 1 | Column access is a write when high |
| din_i | input | WORD_W | Write data |
| dout_o | output | WORD_W | Read data, held between column strobes |
| col_err_o | output | 1 | One-cycle pulse for a column strobe with no open row |
| ref_start_i | input | 1 | Begin a refresh sweep |
| ref_req_o | output | 1 | Refresh interval has expired |
| ref_busy_o | output | 1 | Refresh sweep in progress |

## Verification
The first directed pass fills every supercell with a distinct value, one row at a time, and reads everything back. A swapped row or column index shows up as a wrong value, and so does a lost write-back. After that, a fixed-seed random mix of row switches, closes, reads, writes and stray column strobes runs against a bench model of the array and the buffer. It exposes write-back ordering faults, faults in which dout_o is held or cleared, and faults in the error pulse. Directed cases then cover simultaneous row and column strobes on the open row, a refresh request issued while a row is open, and a complete refresh sweep. The sweep is checked for its busy length, for ignored strobes and for unchanged contents, and the flag interval is measured exactly afterwards.

// File: rtl/mdram_pkg.sv
package mdram_pkg;
  typedef enum logic {
    PH_LOAD  = 1'b0,
    PH_STORE = 1'b1
  } ref_phase_e;
endpackage

// File: rtl/mdram_cell_array.sv
module mdram_cell_array #(
  parameter int IDX_W = 2,
  parameter int ROW_W = 32,
  localparam int ROWS = 1 << IDX_W
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [ROW_W-1:0] rd_row_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [ROW_W-1:0] wr_row_i
);
  logic [ROW_W-1:0] cells_q [ROWS];

  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      cells_q[wr_idx_i] <= wr_row_i;
    end
  end

  assign rd_row_o = cells_q[rd_idx_i];
endmodule

// File: rtl/mdram_row_buf.sv
module mdram_row_buf #(
  parameter int COL_BITS = 2,
  parameter int WORD_W = 8,
  localparam int COLS = 1 << COL_BITS,
  localparam int ROW_W = COLS * WORD_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_en_i,
  input  logic [ROW_W-1:0]    load_row_i,
  input  logic                col_en_i,
  input  logic [COL_BITS-1:0] col_idx_i,
  input  logic                col_wr_i,
  input  logic [WORD_W-1:0]   din_i,
  input  logic                dout_clr_i,
  output logic [ROW_W-1:0]    row_o,
  output logic [WORD_W-1:0]   dout_o
);
  logic [COLS-1:0][WORD_W-1:0] buf_q, buf_d;
  logic [WORD_W-1:0]           dout_q, dout_d;
  logic                        buf_en, dout_en;

  always_comb begin
    buf_d   = buf_q;
    buf_en  = 1'b0;
    dout_d  = dout_q;
    dout_en = 1'b0;
    if (load_en_i) begin
      buf_d  = load_row_i;
      buf_en = 1'b1;
    end else if (col_en_i && col_wr_i) begin
      buf_d[col_idx_i] = din_i;
      buf_en           = 1'b1;
    end
    if (dout_clr_i) begin
      dout_d  = '0;
      dout_en = 1'b1;
    end else if (col_en_i) begin
      dout_d  = col_wr_i ? din_i : buf_q[col_idx_i];
      dout_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      dout_q <= '0;
    end else begin
      if (buf_en)  buf_q  <= buf_d;
      if (dout_en) dout_q <= dout_d;
    end
  end

  assign row_o  = buf_q;
  assign dout_o = dout_q;
endmodule

// File: rtl/mdram_ctrl.sv
module mdram_ctrl #(
  parameter int ROW_BITS = 2,
  parameter int ADDR_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                row_stb_i,
  input  logic                col_stb_i,
  input  logic                row_close_i,
  input  logic                ref_start_i,
  input  logic                ref_busy_i,
  output logic                open_o,
  output logic [ROW_BITS-1:0] open_row_o,
  output logic                load_en_o,
  output logic                wb_en_o,
  output logic                col_en_o,
  output logic                dout_clr_o,
  output logic                ref_go_o,
  output logic                col_err_o
);
  logic                open_q, open_d;
  logic [ROW_BITS-1:0] row_q, row_d;
  logic                err_q, err_d;
  logic                idle, row_acc, close_acc;

  always_comb begin
    idle      = !ref_busy_i;
    ref_go_o  = ref_start_i && idle && !open_q;
    row_acc   = row_stb_i && idle && !ref_go_o;
    close_acc = row_close_i && open_q && !row_stb_i;
    col_en_o  = col_stb_i && open_q && !row_stb_i && !row_close_i;
    wb_en_o   = (row_acc && open_q) || close_acc;
    load_en_o = row_acc;
    dout_clr_o = wb_en_o;
    err_d     = col_stb_i && !open_q;
    open_d    = open_q;
    row_d     = row_q;
    if (row_acc) begin
      open_d = 1'b1;
      row_d  = addr_i[ROW_BITS-1:0];
    end else if (close_acc) begin
      open_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      row_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      open_q <= open_d;
      err_q  <= err_d;
      if (row_acc) row_q <= row_d;
    end
  end

  assign open_o     = open_q;
  assign open_row_o = row_q;
  assign col_err_o  = err_q;
endmodule

// File: rtl/mdram_refresh.sv
module mdram_refresh
  import mdram_pkg::*;
#(
  parameter int ROW_BITS = 2,
  parameter int REFRESH_CYCLES = 1024,
  localparam int CNT_W = $clog2(REFRESH_CYCLES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go_i,
  output logic                busy_o,
  output logic                req_o,
  output logic [ROW_BITS-1:0] row_o,
  output logic                load_o,
  output logic                store_o
);
  logic                busy_q, busy_d;
  ref_phase_e          ph_q, ph_d;
  logic [ROW_BITS-1:0] rr_q, rr_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic                req_q, req_d;
  logic                done;

  always_comb begin
    busy_d = busy_q;
    ph_d   = ph_q;
    rr_d   = rr_q;
    done   = busy_q && (ph_q == PH_STORE) && (&rr_q);
    if (!busy_q) begin
      if (go_i) begin
        busy_d = 1'b1;
        ph_d   = PH_LOAD;
        rr_d   = '0;
      end
    end else if (ph_q == PH_LOAD) begin
      ph_d = PH_STORE;
    end else begin
      ph_d = PH_LOAD;
      if (done) busy_d = 1'b0;
      else      rr_d   = rr_q + 1'b1;
    end
    cnt_d = cnt_q;
    req_d = req_q;
    if (done) begin
      cnt_d = '0;
      req_d = 1'b0;
    end else if (!req_q) begin
      if (cnt_q == CNT_W'(REFRESH_CYCLES - 1)) req_d = 1'b1;
      else                                     cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ph_q   <= PH_LOAD;
      rr_q   <= '0;
      cnt_q  <= '0;
      req_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      ph_q   <= ph_d;
      rr_q   <= rr_d;
      cnt_q  <= cnt_d;
      req_q  <= req_d;
    end
  end

  assign busy_o  = busy_q;
  assign req_o   = req_q;
  assign row_o   = rr_q;
  assign load_o  = busy_q && (ph_q == PH_LOAD);
  assign store_o = busy_q && (ph_q == PH_STORE);
endmodule

// File: rtl/mux_dram_core.sv
module mux_dram_core #(
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 2,
  parameter int WORD_W = 8,
  parameter int REFRESH_CYCLES = 1024,
  localparam int ADDR_W = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              row_stb_i,
  input  logic              col_stb_i,
  input  logic              row_close_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] din_i,
  output logic [WORD_W-1:0] dout_o,
  output logic              col_err_o,
  input  logic              ref_start_i,
  output logic              ref_req_o,
  output logic              ref_busy_o
);
  localparam int ROW_W = (1 << COL_BITS) * WORD_W;

  logic [1:0]          rst_sync_q;
  logic                rst_core_n;
  logic                row_open, load_en, wb_en, col_en, dout_clr, ref_go;
  logic [ROW_BITS-1:0] open_row, ref_row, req_row, arr_rd_idx, arr_wr_idx;
  logic                ref_load, ref_store;
  logic [ROW_W-1:0]    arr_rd_row, buf_row, buf_load_row;
  logic                arr_wr_en, buf_load_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  mdram_ctrl #(.ROW_BITS(ROW_BITS), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst_n(rst_core_n), .addr_i(addr_i),
    .row_stb_i(row_stb_i), .col_stb_i(col_stb_i), .row_close_i(row_close_i),
    .ref_start_i(ref_start_i), .ref_busy_i(ref_busy_o),
    .open_o(row_open), .open_row_o(open_row), .load_en_o(load_en),
    .wb_en_o(wb_en), .col_en_o(col_en), .dout_clr_o(dout_clr),
    .ref_go_o(ref_go), .col_err_o(col_err_o)
  );

  mdram_refresh #(.ROW_BITS(ROW_BITS), .REFRESH_CYCLES(REFRESH_CYCLES)) refresh_i (
    .clk(clk), .rst_n(rst_core_n), .go_i(ref_go),
    .busy_o(ref_busy_o), .req_o(ref_req_o), .row_o(ref_row),
    .load_o(ref_load), .store_o(ref_store)
  );

  assign req_row      = addr_i[ROW_BITS-1:0];
  assign arr_rd_idx   = ref_busy_o ? ref_row : req_row;
  assign arr_wr_idx   = ref_busy_o ? ref_row : open_row;
  assign arr_wr_en    = wb_en || ref_store;
  assign buf_load_en  = load_en || ref_load;
  // Reopening the row being written back must see the buffer, not the stale array row.
  assign buf_load_row = (wb_en && (open_row == req_row) && !ref_busy_o) ? buf_row : arr_rd_row;

  mdram_cell_array #(.IDX_W(ROW_BITS), .ROW_W(ROW_W)) array_i (
    .clk(clk), .rd_idx_i(arr_rd_idx), .rd_row_o(arr_rd_row),
    .wr_en_i(arr_wr_en), .wr_idx_i(arr_wr_idx), .wr_row_i(buf_row)
  );

  mdram_row_buf #(.COL_BITS(COL_BITS), .WORD_W(WORD_W)) rowbuf_i (
    .clk(clk), .rst_n(rst_core_n),
    .load_en_i(buf_load_en), .load_row_i(buf_load_row),
    .col_en_i(col_en), .col_idx_i(addr_i[COL_BITS-1:0]), .col_wr_i(wr_en_i),
    .din_i(din_i), .dout_clr_i(dout_clr),
    .row_o(buf_row), .dout_o(dout_o)
  );
endmodule

// File: rtl/mdram_chk.sv
module mdram_chk #(
  parameter int WORD_W = 8,
  parameter int BUSY_LEN = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              row_stb_i,
  input logic              col_stb_i,
  input logic              row_close_i,
  input logic              ref_start_i,
  input logic              row_open,
  input logic [WORD_W-1:0] dout_o,
  input logic              col_err_o,
  input logic              ref_req_o,
  input logic              ref_busy_o
);
  logic [15:0] run_len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run_len_q <= '0;
    else if (ref_busy_o) run_len_q <= run_len_q + 16'd1;
    else                 run_len_q <= '0;
  end

  // R7
  err_on_stray_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_stb_i && !row_open) |=> col_err_o);
  // R7
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(col_stb_i && !row_open) |=> !col_err_o);
  // R6
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!col_stb_i && !row_stb_i && !row_close_i) |=> $stable(dout_o));
  // R2
  switch_clears_dout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_stb_i && row_open) |=> (dout_o == '0));
  // R9
  busy_no_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_busy_o |-> !row_open);
  // R9
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ref_busy_o) |-> (run_len_q == 16'(BUSY_LEN)));
  // R10
  ref_ignored_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_start_i && row_open) |=> !ref_busy_o);
  // R8
  req_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req_o && !ref_busy_o) |=> ref_req_o);
endmodule

bind mux_dram_core mdram_chk #(.WORD_W(WORD_W), .BUSY_LEN(2 * (1 << ROW_BITS))) chk_i (
  .clk(clk), .rst_n(rst_core_n), .row_stb_i(row_stb_i), .col_stb_i(col_stb_i),
  .row_close_i(row_close_i), .ref_start_i(ref_start_i), .row_open(row_open),
  .dout_o(dout_o), .col_err_o(col_err_o), .ref_req_o(ref_req_o), .ref_busy_o(ref_busy_o)
);

// File: tb/mux_dram_core_tb_top.sv
module mux_dram_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TB_REFRESH = 64;

  logic       clk, rst_n;
  logic [1:0] addr;
  logic       row_stb, col_stb, row_close, wr_en, ref_start;
  logic [7:0] din, dout;
  logic       col_err, ref_req, ref_busy;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  logic [7:0] m_arr [16];
  logic [7:0] m_buf [4];
  bit         m_open;
  int         m_row;
  logic [7:0] m_dout;

  mux_dram_core #(.ROW_BITS(2), .COL_BITS(2), .WORD_W(8), .REFRESH_CYCLES(TB_REFRESH)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .row_stb_i(row_stb), .col_stb_i(col_stb),
    .row_close_i(row_close), .wr_en_i(wr_en), .din_i(din), .dout_o(dout),
    .col_err_o(col_err), .ref_start_i(ref_start), .ref_req_o(ref_req), .ref_busy_o(ref_busy)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic rs, input logic cs, input logic cl, input logic we,
                      input logic rf, input logic [1:0] a, input logic [7:0] d);
    row_stb = rs; col_stb = cs; row_close = cl; wr_en = we; ref_start = rf;
    addr = a; din = d;
    @(negedge clk);
    row_stb = 0; col_stb = 0; row_close = 0; wr_en = 0; ref_start = 0;
  endtask

  function automatic void m_writeback();
    for (int c = 0; c < 4; c++) m_arr[m_row * 4 + c] = m_buf[c];
  endfunction

  task automatic do_row(input int r);
    step(1, 0, 0, 0, 0, 2'(r), 8'h00);
    if (m_open) begin m_writeback(); m_dout = 8'h00; end
    for (int c = 0; c < 4; c++) m_buf[c] = m_arr[r * 4 + c];
    m_open = 1; m_row = r;
    chk(dout == m_dout, "R2 dout after row strobe", dout, m_dout);
  endtask

  task automatic do_close();
    step(0, 0, 1, 0, 0, 2'd0, 8'h00);
    if (m_open) begin m_writeback(); m_dout = 8'h00; m_open = 0; end
    chk(dout == m_dout, "R6 dout after close", dout, m_dout);
  endtask

  task automatic do_col(input int c, input bit we, input logic [7:0] d);
    step(0, 1, 0, we, 0, 2'(c), d);
    if (!m_open) begin
      chk(col_err == 1'b1, "R7 error pulse on stray column", col_err, 1);
      chk(dout == m_dout, "R7 dout untouched by stray column", dout, m_dout);
    end else begin
      if (we) begin m_buf[c] = d; m_dout = d; end
      else    m_dout = m_buf[c];
      chk(dout == m_dout, we ? "R4 write echo" : "R3 read data", dout, m_dout);
      chk(col_err == 1'b0, "R3 no error with open row", col_err, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'h5EED_0042));
    rst_n = 0; row_stb = 0; col_stb = 0; row_close = 0; wr_en = 0; ref_start = 0;
    addr = 0; din = 0;
    m_open = 0; m_row = 0; m_dout = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(dout == 8'h00, "R1 dout reset", dout, 0);
    chk(col_err == 1'b0, "R1 err reset", col_err, 0);
    chk(ref_req == 1'b0, "R1 ref_req reset", ref_req, 0);
    chk(ref_busy == 1'b0, "R1 ref_busy reset", ref_busy, 0);
    do_col(1, 0, 8'h00);                       // R1 no row open after reset
    step(0, 0, 0, 0, 0, 2'd0, 8'h00);
    chk(col_err == 1'b0, "R7 error lasts one cycle", col_err, 0);

    // R5 fill every supercell with a distinct value, then read all back
    for (int r = 0; r < 4; r++) begin
      do_row(r);
      for (int c = 0; c < 4; c++) do_col(c, 1, 8'(8'h11 * (r + 1) + 8'(c * 3)));
    end
    do_close();
    for (int r = 0; r < 4; r++) begin
      do_row(r);
      for (int c = 0; c < 4; c++) begin
        do_col(c, 0, 8'h00);
        chk(dout == 8'(8'h11 * (r + 1) + 8'(c * 3)), "R5 stored value", dout,
            8'(8'h11 * (r + 1) + 8'(c * 3)));
      end
    end
    do_close();

    // R6 dout hold across idle cycles
    do_row(2);
    do_col(3, 0, 8'h00);
    repeat (3) step(0, 0, 0, 0, 0, 2'd1, 8'hFF);
    chk(dout == m_dout, "R6 dout held while idle", dout, m_dout);

    // R11 row strobe with column strobe on open row: column ignored, buffered write kept
    do_col(2, 1, 8'hA5);
    step(1, 1, 0, 1, 0, 2'd2, 8'h3C);
    m_writeback(); m_dout = 8'h00;
    chk(dout == 8'h00, "R11 row wins over column", dout, 0);
    do_col(2, 0, 8'h00);
    chk(dout == 8'hA5, "R11 reopen keeps buffered write", dout, 8'hA5);
    step(0, 1, 1, 1, 0, 2'd0, 8'h77);          // close wins over column write
    m_writeback(); m_open = 0; m_dout = 8'h00;
    chk(dout == 8'h00, "R11 close wins over column", dout, 0);
    do_row(2);
    do_col(0, 0, 8'h00);
    chk(dout == m_arr[8], "R11 column write dropped under close", dout, m_arr[8]);

    // R10 refresh refused with row open
    step(0, 0, 0, 0, 1, 2'd0, 8'h00);
    chk(ref_busy == 1'b0, "R10 refresh ignored with open row", ref_busy, 0);

    // Random mix against the model
    for (int i = 0; i < 600; i++) begin
      int op = int'($urandom_range(0, 9));
      int a  = int'($urandom_range(0, 3));
      if (op < 2)      do_row(a);
      else if (op < 3) do_close();
      else if (op < 6) do_col(a, 0, 8'h00);
      else             do_col(a, 1, 8'($urandom));
    end
    do_close();

    // R8 flag must be up by now
    chk(ref_req == 1'b1, "R8 ref_req raised after interval", ref_req, 1);

    // R9 refresh sweep: length, ignored strobes, flag cleared
    step(0, 0, 0, 0, 1, 2'd0, 8'h00);
    n = 0;
    while (ref_busy && n < 100) begin
      n++;
      row_stb = 1; addr = 2'd1;
      @(negedge clk);
    end
    row_stb = 0;
    chk(n == 8, "R9 busy length", n, 8);
    chk(ref_req == 1'b0, "R9 flag cleared after sweep", ref_req, 0);

    // R8 exact interval after sweep
    n = 0;
    while (!ref_req && n < 1000) begin
      @(negedge clk);
      n++;
    end
    chk(n == TB_REFRESH, "R8 interval length", n, TB_REFRESH);

    do_col(0, 0, 8'h00);
    chk(col_err == 1'b1, "R9 strobe during sweep opened nothing", col_err, 1);
    for (int r = 0; r < 4; r++) begin
      do_row(r);
      for (int c = 0; c < 4; c++) begin
        do_col(c, 0, 8'h00);
        chk(dout == m_arr[r * 4 + c], "R9 contents preserved", dout, m_arr[r * 4 + c]);
      end
    end
    do_close();

    done_flag = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule